// File: doc/BRIEF.md
# Asynchronous Serial Interface Adapter

This block connects a byte-wide processor bus to a pair of asynchronous serial lines. Two register locations, chosen by a single address bit, carry the traffic. Location 0 takes control writes and returns status on reads. Location 1 takes the byte to send on writes and returns the last byte received on reads. The transmitter and receiver run at a bit period of twice a selectable clock divider (1, 16 or 64 input clocks). The frame holds 7 or 8 data bits and 1 or 2 stop bits. The status register also reports two modem inputs, carrier detect and clear-to-send.

A single interrupt output is the OR of three sticky causes: transmit-needs-write, receive-needs-read and status-needs-read. Whenever either of the first two is raised, status-needs-read is raised with it. A handler therefore has to read status and also service the data register before the line drops. A one-cycle change pulse marks every rising and falling transition of the interrupt line.

Top module: `serial_adapter`

## Requirements
- R1: After reset the serial output is high, the interrupt and change outputs are low, the control register is all zero, and status reads 0x02 when both modem inputs are low.
- R2: The status byte is laid out as bit0 receive full, bit1 transmit holding empty, bit2 carrier detect input, bit3 clear-to-send input, bit7 interrupt pending, with bits 6:4 zero.
- R3: A transmitted frame is one start bit (0), then the data LSB first, then 1s for the stop bits. Control bit2 set selects 7 data bits, and control bit3 set selects 2 stop bits. The line idles high.
- R4: Control bits 1:0 select the divider: 00 gives 1, 01 gives 16 and 10 gives 64. Every transmitted bit lasts exactly twice the divider in clock cycles.
- R5: A data write fills the holding register, so status bit1 reads 0 in the next cycle. An idle shifter takes the byte one cycle after the write, and bit1 then reads 1 again.
- R6: A control write with bits 1:0 equal to 11 aborts the transmitter. From the next cycle the line is high and the holding register is empty. This write leaves the stored control fields unchanged.
- R7: The receiver starts on a falling edge of the serial input and samples each bit at mid-period. A 7-bit frame reads back with bit7 zero. Reading location 1 returns the byte and clears status bit0.
- R8: A frame whose final stop bit samples low is discarded, so receive full stays 0.
- R9: When control bit4 is set and a byte moves from the holding register to the shifter, transmit-needs-write is raised. A data write clears it.
- R10: When control bit5 is set and a frame completes, receive-needs-read is raised. A read of location 1 clears it.
- R11: Raising any cause also raises status-needs-read. A status read clears only status-needs-read. The interrupt output stays high while any cause remains.
- R12: The change output pulses for exactly the first cycle of each rising and falling transition of the interrupt output.
- R13: With both interrupt enables clear, completed frames and emptied holding registers leave the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd_i | input | 1 | Read strobe; side effects at the clock edge |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 1 | 0 = control/status, 1 = data |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| dcd_i | input | 1 | Carrier detect modem input |
| cts_i | input | 1 | Clear-to-send modem input |
| irq_o | output | 1 | Interrupt request |
| irq_chg_o | output | 1 | One-cycle pulse on each interrupt transition |

## Verification
Register writes and read side effects take effect at the edge that ends the strobe cycle. Status and data checks therefore sample in the cycle after that edge. An idle transmitter loads its shifter one edge after the data write. The start bit then holds for 2×divider cycles, so line checks sample each bit at its middle and test the period at its last and first cycles. A received byte becomes readable one edge after the mid-point of the last stop bit, and the bench waits out the whole frame plus two cycles before it reads. The interrupt and change outputs are compared every cycle against the previous interrupt level.

// File: rtl/serial_adapter_pkg.sv
package serial_adapter_pkg;
   localparam int BYTE_W  = 8;
   localparam int FRAME_W = 11;
   localparam int CNT_W   = 4;
   localparam int C_TXW   = 0;
   localparam int C_RXR   = 1;
   localparam int C_STAT  = 2;
   localparam int N_CAUSE = 3;

   typedef struct packed {
      logic       rx_ie;
      logic       tx_ie;
      logic       two_stop;
      logic       seven;
      logic [1:0] div_sel;
   } ctrl_t;
endpackage

// File: rtl/sa_tx.sv
module sa_tx
   import serial_adapter_pkg::*;
#(
   parameter int TICK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic [TICK_W-1:0] period_i,
   input  logic              seven_i,
   input  logic              two_stop_i,
   input  logic              wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic              hold_empty_o,
   output logic              moved_o,
   output logic              txd_o
);
   logic [BYTE_W-1:0]  hold_q;
   logic               hold_full_q;
   logic               busy_q;
   logic [FRAME_W-1:0] sh_q;
   logic [FRAME_W-1:0] framed;
   logic [CNT_W-1:0]   left_q;
   logic [CNT_W-1:0]   total;
   logic [TICK_W-1:0]  tick_q;
   logic               load;

   assign load = hold_full_q & ~busy_q & ~flush_i;

   always_comb begin
      framed = seven_i ? {3'b111, hold_q[6:0], 1'b0} : {2'b11, hold_q, 1'b0};
      total  = 4'd10 - {3'b000, seven_i} + {3'b000, two_stop_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         busy_q      <= 1'b0;
         sh_q        <= '1;
         left_q      <= '0;
         tick_q      <= '0;
      end else if (flush_i) begin
         hold_full_q <= 1'b0;
         busy_q      <= 1'b0;
         sh_q        <= '1;
         tick_q      <= '0;
      end else begin
         if (load) begin
            hold_full_q <= 1'b0;
            busy_q      <= 1'b1;
            sh_q        <= framed;
            left_q      <= total;
            tick_q      <= '0;
         end else if (busy_q) begin
            if (tick_q == period_i - 1'b1) begin
               tick_q <= '0;
               sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
               left_q <= left_q - 1'b1;
               if (left_q == 4'd1) busy_q <= 1'b0;
            end else begin
               tick_q <= tick_q + 1'b1;
            end
         end
         if (wr_i) begin
            hold_q      <= wdata_i;
            hold_full_q <= 1'b1;
         end
      end
   end

   assign txd_o        = busy_q ? sh_q[0] : 1'b1;
   assign hold_empty_o = ~hold_full_q;
   assign moved_o      = load;

   assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !txd_o);
   assert_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && tick_q != '0) |-> $stable(txd_o));
   assert_hold_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> !hold_empty_o);
endmodule

// File: rtl/sa_rx.sv
module sa_rx
   import serial_adapter_pkg::*;
#(
   parameter int TICK_W = 8,
   parameter int SYNC   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd_i,
   input  logic [TICK_W-1:0] half_i,
   input  logic [TICK_W-1:0] period_i,
   input  logic              seven_i,
   input  logic              two_stop_i,
   output logic              done_o,
   output logic [BYTE_W-1:0] data_o
);
   logic              line;
   logic              prev_q;
   logic              busy_q;
   logic              good_q;
   logic [CNT_W-1:0]  idx_q;
   logic [CNT_W-1:0]  ndata;
   logic [CNT_W-1:0]  last;
   logic [TICK_W-1:0] tick_q;
   logic [BYTE_W-1:0] sr_q;

   generate
      if (SYNC == 0) begin : g_direct
         assign line = rxd_i;
      end else begin : g_sync
         logic [SYNC-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else begin
               chain_q[0] <= rxd_i;
               for (int i = 1; i < SYNC; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign line = chain_q[SYNC-1];
      end
   endgenerate

   assign ndata = seven_i ? 4'd7 : 4'd8;
   assign last  = 4'd9 - {3'b000, seven_i} + {3'b000, two_stop_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         busy_q <= 1'b0;
         good_q <= 1'b0;
         idx_q  <= '0;
         tick_q <= '0;
         sr_q   <= '0;
         done_o <= 1'b0;
      end else begin
         prev_q <= line;
         done_o <= 1'b0;
         if (!busy_q) begin
            if (prev_q && !line) begin
               busy_q <= 1'b1;
               tick_q <= TICK_W'(1);
               idx_q  <= '0;
               good_q <= 1'b1;
            end
         end else begin
            tick_q <= (tick_q == period_i - 1'b1) ? '0 : tick_q + 1'b1;
            if (tick_q == half_i) begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == '0) begin
                  if (line) busy_q <= 1'b0;
               end else if (idx_q <= ndata) begin
                  sr_q <= {line, sr_q[BYTE_W-1:1]};
               end else if (idx_q == last) begin
                  busy_q <= 1'b0;
                  done_o <= good_q & line;
               end else begin
                  good_q <= good_q & line;
               end
            end
         end
      end
   end

   assign data_o = seven_i ? {1'b0, sr_q[BYTE_W-1:1]} : sr_q;

   assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> idx_q <= last);
endmodule

// File: rtl/sa_irq.sv
module sa_irq
   import serial_adapter_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CAUSE-1:0] set_i,
   input  logic [N_CAUSE-1:0] clr_i,
   output logic               irq_o,
   output logic               chg_o
);
   logic [N_CAUSE-1:0] cause_q;
   logic [N_CAUSE-1:0] set_all;
   logic [N_CAUSE-1:0] nxt;

   always_comb begin
      set_all = set_i;
      if (|set_i) set_all[C_STAT] = 1'b1;
      nxt = (cause_q & ~clr_i) | set_all;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         chg_o   <= 1'b0;
      end else begin
         cause_q <= nxt;
         chg_o   <= (|nxt) != (|cause_q);
      end
   end

   assign irq_o = |cause_q;

   assert_stat_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> cause_q[C_STAT]);
   assert_chg_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
      chg_o |-> (irq_o != $past(irq_o)));
   assert_edge_chg_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o != $past(irq_o)) |-> chg_o);
endmodule

// File: rtl/serial_adapter.sv
module serial_adapter
   import serial_adapter_pkg::*;
#(
   parameter int DIV_MID = 16,
   parameter int DIV_HI  = 64,
   parameter int RX_SYNC = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rd_i,
   input  logic       bus_wr_i,
   input  logic       bus_addr_i,
   input  logic [7:0] bus_wdata_i,
   output logic [7:0] bus_rdata_o,
   output logic       txd_o,
   input  logic       rxd_i,
   input  logic       dcd_i,
   input  logic       cts_i,
   output logic       irq_o,
   output logic       irq_chg_o
);
   localparam int TICK_W = $clog2(2 * DIV_HI) + 1;

   generate
      if (DIV_MID < 1 || DIV_HI < DIV_MID) begin : g_bad_div
         $error("serial_adapter: dividers must satisfy 1 <= DIV_MID <= DIV_HI");
      end
      if (RX_SYNC < 0 || RX_SYNC > 4) begin : g_bad_sync
         $error("serial_adapter: RX_SYNC must be 0..4");
      end
   endgenerate

   ctrl_t              ctrl_q;
   logic [TICK_W-1:0]  div_v;
   logic [TICK_W-1:0]  period;
   logic               flush;
   logic               data_wr;
   logic               hold_empty;
   logic               moved;
   logic               rx_done;
   logic [BYTE_W-1:0]  rx_data;
   logic [BYTE_W-1:0]  rx_buf_q;
   logic               rx_full_q;
   logic [N_CAUSE-1:0] set_v;
   logic [N_CAUSE-1:0] clr_v;
   logic               unused_wdata;

   assign unused_wdata = ^bus_wdata_i[7:6];
   assign flush   = bus_wr_i & ~bus_addr_i & (bus_wdata_i[1:0] == 2'b11);
   assign data_wr = bus_wr_i & bus_addr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else if (bus_wr_i && !bus_addr_i && !flush) ctrl_q <= ctrl_t'(bus_wdata_i[5:0]);
   end

   always_comb begin
      case (ctrl_q.div_sel)
         2'b01:   div_v = TICK_W'(DIV_MID);
         2'b10:   div_v = TICK_W'(DIV_HI);
         default: div_v = TICK_W'(1);
      endcase
      period = div_v << 1;
   end

   sa_tx #(.TICK_W(TICK_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .flush_i(flush), .period_i(period),
      .seven_i(ctrl_q.seven), .two_stop_i(ctrl_q.two_stop),
      .wr_i(data_wr), .wdata_i(bus_wdata_i),
      .hold_empty_o(hold_empty), .moved_o(moved), .txd_o(txd_o)
   );

   sa_rx #(.TICK_W(TICK_W), .SYNC(RX_SYNC)) u_rx (
      .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .half_i(div_v), .period_i(period),
      .seven_i(ctrl_q.seven), .two_stop_i(ctrl_q.two_stop),
      .done_o(rx_done), .data_o(rx_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_buf_q  <= '0;
         rx_full_q <= 1'b0;
      end else if (rx_done) begin
         rx_buf_q  <= rx_data;
         rx_full_q <= 1'b1;
      end else if (bus_rd_i && bus_addr_i) begin
         rx_full_q <= 1'b0;
      end
   end

   always_comb begin
      set_v         = '0;
      set_v[C_TXW]  = moved & ctrl_q.tx_ie;
      set_v[C_RXR]  = rx_done & ctrl_q.rx_ie;
      clr_v         = '0;
      clr_v[C_TXW]  = data_wr;
      clr_v[C_RXR]  = bus_rd_i & bus_addr_i;
      clr_v[C_STAT] = bus_rd_i & ~bus_addr_i;
   end

   sa_irq u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v),
      .irq_o(irq_o), .chg_o(irq_chg_o)
   );

   assign bus_rdata_o = bus_addr_i ? rx_buf_q
                                   : {irq_o, 3'b000, cts_i, dcd_i, hold_empty, rx_full_q};

   assert_rx_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> rx_full_q);
   assert_tx_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (moved && ctrl_q.tx_ie) |=> irq_o);
   assert_flush_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (txd_o && hold_empty));
endmodule

// File: tb/tb_serial_adapter.sv
module tb_serial_adapter;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n, rd, wr, addr, rxd, dcd, cts;
   logic [7:0] wdata, rdata;
   logic       txd, irq, chg;
   int         checks = 0, errors = 0, pulses = 0, chg_err = 0;
   logic       irq_prev = 1'b0;
   logic [7:0] v;
   logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81, 8'h3C};

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_adapter dut (
      .clk(clk), .rst_n(rst_n), .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .txd_o(txd), .rxd_i(rxd),
      .dcd_i(dcd), .cts_i(cts), .irq_o(irq), .irq_chg_o(chg)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic exp_bit(input logic [7:0] b, input int i, input logic seven);
      int n = seven ? 7 : 8;
      if (i == 0) return 1'b0;
      if (i <= n) return b[i-1];
      return 1'b1;
   endfunction

   task automatic bus_wr(input logic a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic a, output logic [7:0] d);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic tx_frame(input logic [7:0] b, input int d, input logic seven, input logic two);
      int total = 10 - int'(seven) + int'(two);
      logic [10:0] got = '1, exp = '1;
      bus_wr(1'b1, b);
      repeat (1 + d) @(negedge clk);
      for (int i = 0; i < total; i++) begin
         got[i] = txd;
         exp[i] = exp_bit(b, i, seven);
         if (i < total - 1) repeat (2 * d) @(negedge clk);
      end
      repeat (d + 2) @(negedge clk);
      chk("R3 tx frame", {21'b0, got}, {21'b0, exp});
   endtask

   task automatic tx_period(input int d, input string req);
      bus_wr(1'b1, 8'hFF);
      repeat (2 * d) @(negedge clk);
      chk({req, " start bit last cycle"}, {31'b0, txd}, 32'd0);
      @(negedge clk);
      chk({req, " bit0 first cycle"}, {31'b0, txd}, 32'd1);
      repeat (2 * d * 11) @(negedge clk);
   endtask

   task automatic rx_frame(input logic [7:0] b, input int d, input logic seven,
                           input logic two, input logic stop_ok);
      int total = 10 - int'(seven) + int'(two);
      for (int i = 0; i < total; i++) begin
         rxd = (i == total - 1 && !stop_ok) ? 1'b0 : exp_bit(b, i, seven);
         repeat (2 * d) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (chg !== (irq !== irq_prev)) chg_err++;
         if (chg === 1'b1) pulses++;
         irq_prev = irq;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rd = 1'b0; wr = 1'b0; addr = 1'b0; wdata = '0;
      rxd = 1'b1; dcd = 1'b0; cts = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk("R1 txd idle", {31'b0, txd}, 32'd1);
      chk("R1 irq low", {30'b0, irq, chg}, 32'd0);
      bus_rd(1'b0, v);
      chk("R1 status", {24'b0, v}, 32'h02);

      for (int i = 0; i < 4; i++) begin
         dcd = i[0]; cts = i[1];
         @(negedge clk);
         bus_rd(1'b0, v);
         chk("R2 modem bits", {24'b0, v}, 32'h02 | (i << 2));
      end
      dcd = 1'b0; cts = 1'b0;

      bus_wr(1'b1, 8'h00);
      bus_rd(1'b0, v);
      chk("R5 holding full", {31'b0, v[1]}, 32'd0);
      bus_rd(1'b0, v);
      chk("R5 holding moved", {31'b0, v[1]}, 32'd1);
      repeat (30) @(negedge clk);

      for (int c = 0; c < 4; c++) begin
         bus_wr(1'b0, {4'b0, c[1], c[0], 2'b00});
         foreach (pats[p]) tx_frame(pats[p], 1, c[0], c[1]);
      end
      bus_wr(1'b0, 8'h0D);
      tx_frame(8'hC3, 16, 1'b1, 1'b1);
      bus_wr(1'b0, 8'h02);
      tx_period(64, "R4 div64");
      bus_wr(1'b0, 8'h01);
      tx_period(16, "R4 div16");

      bus_wr(1'b1, 8'h00);
      repeat (5) @(negedge clk);
      chk("R6 mid start bit", {31'b0, txd}, 32'd0);
      bus_wr(1'b0, 8'h03);
      chk("R6 line high after reset", {31'b0, txd}, 32'd1);
      bus_rd(1'b0, v);
      chk("R6 holding empty", {31'b0, v[1]}, 32'd1);
      tx_period(16, "R6 divider kept");

      for (int c = 0; c < 4; c++) begin
         bus_wr(1'b0, {4'b0, c[1], c[0], 2'b00});
         foreach (pats[p]) begin
            rx_frame(pats[p], 1, c[0], c[1], 1'b1);
            bus_rd(1'b0, v);
            chk("R7 status full", {24'b0, v}, 32'h03);
            bus_rd(1'b1, v);
            chk("R7 rx data", {24'b0, v}, {24'b0, c[0] ? (pats[p] & 8'h7F) : pats[p]});
            bus_rd(1'b0, v);
            chk("R7 full cleared", {24'b0, v}, 32'h02);
         end
      end
      bus_wr(1'b0, 8'h01);
      rx_frame(8'h96, 16, 1'b0, 1'b0, 1'b1);
      bus_rd(1'b1, v);
      chk("R7 rx div16", {24'b0, v}, 32'h96);

      bus_wr(1'b0, 8'h00);
      rx_frame(8'h55, 1, 1'b0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      bus_rd(1'b0, v);
      chk("R8 bad stop dropped", {24'b0, v}, 32'h02);

      rx_frame(8'h77, 1, 1'b0, 1'b0, 1'b1);
      chk("R13 rx no irq", {31'b0, irq}, 32'd0);
      bus_rd(1'b0, v);
      chk("R13 status", {24'b0, v}, 32'h03);
      bus_rd(1'b1, v);
      bus_wr(1'b1, 8'h44);
      @(negedge clk);
      chk("R13 tx no irq", {31'b0, irq}, 32'd0);
      repeat (30) @(negedge clk);

      bus_wr(1'b0, 8'h20);
      rx_frame(8'h5A, 1, 1'b0, 1'b0, 1'b1);
      chk("R10 irq on frame", {31'b0, irq}, 32'd1);
      bus_rd(1'b1, v);
      chk("R10 data", {24'b0, v}, 32'h5A);
      chk("R11 status cause holds", {31'b0, irq}, 32'd1);
      bus_rd(1'b0, v);
      chk("R11 status value", {24'b0, v}, 32'h82);
      chk("R11 irq released", {31'b0, irq}, 32'd0);
      rx_frame(8'hA5, 1, 1'b0, 1'b0, 1'b1);
      bus_rd(1'b0, v);
      chk("R11 status first", {24'b0, v}, 32'h83);
      chk("R10 receive cause holds", {31'b0, irq}, 32'd1);
      bus_rd(1'b1, v);
      chk("R10 data read releases", {23'b0, irq, v}, 32'h0A5);

      bus_wr(1'b0, 8'h10);
      bus_wr(1'b1, 8'h11);
      @(negedge clk);
      chk("R9 irq on move", {31'b0, irq}, 32'd1);
      bus_wr(1'b1, 8'h22);
      chk("R11 status cause after write", {31'b0, irq}, 32'd1);
      bus_rd(1'b0, v);
      chk("R9 status", {24'b0, v}, 32'h80);
      chk("R11 irq low", {31'b0, irq}, 32'd0);
      repeat (30) @(negedge clk);
      chk("R9 irq on second move", {31'b0, irq}, 32'd1);
      bus_wr(1'b0, 8'h00);
      bus_wr(1'b1, 8'h33);
      bus_rd(1'b0, v);
      chk("R9 cleanup", {31'b0, irq}, 32'd0);
      repeat (60) @(negedge clk);

      chk("R12 change pulse mismatches", chg_err, 32'd0);
      chk("R12 change pulse count", pulses, 32'd8);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule